// File: doc/BRIEF.md
# Operand Collector with Four-Bank Register File and Slot Reuse Cache

This block is the operand-fetch stage of one scheduler partition. It accepts a decoded instruction with up to four source register indices, a per-slot "used" mask, a per-slot reuse mask and the identifier of the thread (warp) that issues it. It returns the four operand values together with a one-cycle valid pulse. The registers live in four single-ported banks, and the bank is chosen by the low bits of the register index. Reads aimed at the same bank are spread over successive cycles.

A small cache sits beside the banks and is indexed by operand slot. Each slot has two entries. The compiler sets a reuse bit to keep the value a slot has just read. A later instruction from the same warp that names the same register in the same slot takes the value from the cache and does not use a bank read. Because the cache belongs to the partition and not to any one warp, the whole cache is dropped when a different warp issues. The compiler is responsible for the contents of the cache: a register write does not update a cached copy.

A simple write port loads the register file. Write arbitration belongs to another stage.

Top module: `operand_fetch`

## Requirements
- R1: While reset is held and after it is released, `inReady` is 1 and `opValid` is 0.
- R2: A source register is read from bank (index mod 4). When every used source that misses the cache sits in a different bank, `opValid` is high two cycles after the accepting clock edge, and each slot carries the register value of the issuing warp.
- R3: Let C be the largest number of cache-missing used sources that map to one bank, with a minimum of 1. Then `opValid` rises C+1 cycles after the accepting edge. Within a bank, lower slots are served first. All four operands are presented together.
- R4: An instruction is accepted on a clock edge where `instValid` and `inReady` are both 1. `inReady` stays 0 from that acceptance until `opValid` is high. `opValid` is high for exactly one cycle, and `inReady` is 1 in that cycle.
- R5: When an instruction completes, every used slot whose bit is set in `reuseMask` (bit n is slot n) writes its register index and value into that slot's cache position.
- R6: A used source that matches a valid cache entry of its own slot, for the same warp, is supplied from the cache and takes no bank cycle. A register write does not update a cached copy, so a hit returns the value that was cached.
- R7: A register cached in one slot position does not hit when it is named in a different slot.
- R8: Each slot position holds two entries. A fill replaces the entry that was written least recently, so a third distinct register evicts the first.
- R9: When an instruction is accepted from a warp other than the previous one, every cache entry is invalidated before the lookup, so none of its sources hit.
- R10: A slot whose `srcUsed` bit is 0 returns 0, uses no bank and fills no cache entry, even when its reuse bit is set. An instruction with no used slots completes two cycles after acceptance.
- R11: A write on the write port takes effect at the clock edge. Each warp has its own set of registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction present |
| inReady | output | 1 | Stage is idle and can accept |
| warpId | input | 2 | Warp issuing the instruction |
| srcIdx | input | 16 | Four 4-bit source indices, slot n at bits 4n+3:4n |
| srcUsed | input | 4 | Slot n holds a real source |
| reuseMask | input | 4 | Slot n keeps its value in the cache |
| opValid | output | 1 | One-cycle pulse: operands ready |
| opData | output | 128 | Four 32-bit operands, slot n at bits 32n+31:32n |
| wrEn | input | 1 | Register write enable |
| wrWarp | input | 2 | Warp of the written register |
| wrIdx | input | 4 | Index of the written register |
| wrData | input | 32 | Write value |

## Verification
The hardest thing to see from the ports is whether a cache hit happened. A hit only shows as one cycle less of latency, or as a value that is now stale. The stimulus therefore pairs a cached register with a second source that sits in the same bank, so that a miss costs an extra cycle. It also overwrites a cached register through the write port, so that a hit returns the old value. The replacement order and the flush on a warp change are checked in the same way: a chain of fills on one slot, or a switch to another warp and back, is followed by probes whose latency shows which entries are still present.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int SLOTS = 4;
  localparam int WAYS  = 2;

  typedef struct packed {
    logic             accept;
    logic             flush;
    logic [SLOTS-1:0] grant;
    logic [SLOTS-1:0] fill;
  } ctrlStrobe_t;
endpackage

// File: rtl/ofs_control.sv
module ofs_control
  import ofs_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int NUM_BANKS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   instValid,
  input  logic [SLOTS-1:0]       inUsed,
  input  logic [SLOTS-1:0]       inReuse,
  input  logic [SLOTS*$clog2(NUM_REGS)-1:0] inIdx,
  input  logic [SLOTS-1:0]       hitVec,
  input  logic                   warpNew,
  output ctrlStrobe_t            strobe,
  output logic                   inReady,
  output logic                   opValid
);
  localparam int REG_W  = $clog2(NUM_REGS);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic             busy;
  logic [SLOTS-1:0] pend;
  logic [SLOTS-1:0] usedR;
  logic [SLOTS-1:0] reuseR;
  logic [BANK_W-1:0] bankR [SLOTS];
  logic [SLOTS-1:0] grant;
  logic [SLOTS-1:0] remaining;
  logic             done;
  logic             accept;

  assign accept  = instValid && !busy;
  assign inReady = !busy;

  // one read per bank per cycle, lowest pending slot wins
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      grant[s] = busy && pend[s];
      for (int t = 0; t < s; t++) begin
        if (pend[t] && bankR[t] == bankR[s]) grant[s] = 1'b0;
      end
    end
  end

  assign remaining = pend & ~grant;
  assign done      = busy && (remaining == '0);

  always_comb begin
    strobe.accept = accept;
    strobe.flush  = accept && warpNew;
    strobe.grant  = grant;
    strobe.fill   = done ? (usedR & reuseR) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      pend    <= '0;
      usedR   <= '0;
      reuseR  <= '0;
      opValid <= 1'b0;
    end else begin
      opValid <= done;
      if (accept) begin
        busy   <= 1'b1;
        pend   <= inUsed & ~hitVec;
        usedR  <= inUsed;
        reuseR <= inReuse;
      end else if (busy) begin
        pend <= remaining;
        if (done) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int s = 0; s < SLOTS; s++) bankR[s] <= inIdx[s*REG_W +: BANK_W];
    end
  end
endmodule

// File: rtl/ofs_datapath.sv
module ofs_datapath
  import ofs_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 16,
  parameter int NUM_WARPS = 4,
  parameter int NUM_BANKS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [$clog2(NUM_WARPS)-1:0] inWarp,
  input  logic [SLOTS*$clog2(NUM_REGS)-1:0] inIdx,
  input  logic [SLOTS-1:0]       inUsed,
  input  logic                   wrEn,
  input  logic [$clog2(NUM_WARPS)-1:0] wrWarp,
  input  logic [$clog2(NUM_REGS)-1:0]  wrIdx,
  input  logic [DATA_W-1:0]      wrData,
  output logic [SLOTS-1:0]       hitVec,
  output logic                   warpNew,
  output logic [SLOTS*DATA_W-1:0] opData
);
  localparam int REG_W      = $clog2(NUM_REGS);
  localparam int WARP_W     = $clog2(NUM_WARPS);
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int BANK_DEPTH = NUM_WARPS * NUM_REGS / NUM_BANKS;

  logic [DATA_W-1:0] bankMem [NUM_BANKS][BANK_DEPTH];

  logic [WARP_W-1:0] curWarp;
  logic [REG_W-1:0]  curIdx  [SLOTS];
  logic [DATA_W-1:0] opReg   [SLOTS];
  logic [DATA_W-1:0] readData[SLOTS];

  logic              ownerValid;
  logic [WARP_W-1:0] ownerWarp;
  logic              cValid [SLOTS][WAYS];
  logic [REG_W-1:0]  cTag   [SLOTS][WAYS];
  logic [DATA_W-1:0] cData  [SLOTS][WAYS];
  logic              cVictim[SLOTS];
  logic [DATA_W-1:0] hitData[SLOTS];

  assign warpNew = !ownerValid || (inWarp != ownerWarp);

  // per-slot tag compare against the two entries of its position
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [REG_W-1:0] idxS;
    logic             m0, m1;
    assign idxS       = inIdx[s*REG_W +: REG_W];
    assign m0         = cValid[s][0] && (cTag[s][0] == idxS);
    assign m1         = cValid[s][1] && (cTag[s][1] == idxS);
    assign hitVec[s]  = !warpNew && (m0 || m1);
    assign hitData[s] = m0 ? cData[s][0] : cData[s][1];
    assign opData[s*DATA_W +: DATA_W] = opReg[s];
  end

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      readData[s] = bankMem[curIdx[s][BANK_W-1:0]][{curWarp, curIdx[s][REG_W-1:BANK_W]}];
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (wrIdx[BANK_W-1:0] == BANK_W'(b))
          bankMem[b][{wrWarp, wrIdx[REG_W-1:BANK_W]}] <= wrData;
      end
    end
  end

  // instruction latch and operand registers
  always_ff @(posedge clk) begin
    if (strobe.accept) begin
      curWarp <= inWarp;
      for (int s = 0; s < SLOTS; s++) begin
        curIdx[s] <= inIdx[s*REG_W +: REG_W];
        opReg[s]  <= (inUsed[s] && hitVec[s]) ? hitData[s] : '0;
      end
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (strobe.grant[s]) opReg[s] <= readData[s];
      end
    end
  end

  // cache payload
  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (strobe.fill[s]) begin
        cTag[s][cVictim[s]]  <= curIdx[s];
        cData[s][cVictim[s]] <= strobe.grant[s] ? readData[s] : opReg[s];
      end
    end
  end

  // cache state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerValid <= 1'b0;
      ownerWarp  <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        cVictim[s] <= 1'b0;
        for (int w = 0; w < WAYS; w++) cValid[s][w] <= 1'b0;
      end
    end else begin
      if (strobe.accept) begin
        ownerValid <= 1'b1;
        ownerWarp  <= inWarp;
      end
      if (strobe.flush) begin
        for (int s = 0; s < SLOTS; s++) begin
          cVictim[s] <= 1'b0;
          for (int w = 0; w < WAYS; w++) cValid[s][w] <= 1'b0;
        end
      end else begin
        for (int s = 0; s < SLOTS; s++) begin
          if (strobe.fill[s]) begin
            cValid[s][cVictim[s]] <= 1'b1;
            cVictim[s]            <= !cVictim[s];
          end
        end
      end
    end
  end
endmodule

// File: rtl/operand_fetch.sv
module operand_fetch
  import ofs_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 16,
  parameter int NUM_WARPS = 4,
  parameter int NUM_BANKS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          instValid,
  output logic                          inReady,
  input  logic [$clog2(NUM_WARPS)-1:0]  warpId,
  input  logic [SLOTS*$clog2(NUM_REGS)-1:0] srcIdx,
  input  logic [SLOTS-1:0]              srcUsed,
  input  logic [SLOTS-1:0]              reuseMask,
  output logic                          opValid,
  output logic [SLOTS*DATA_W-1:0]       opData,
  input  logic                          wrEn,
  input  logic [$clog2(NUM_WARPS)-1:0]  wrWarp,
  input  logic [$clog2(NUM_REGS)-1:0]   wrIdx,
  input  logic [DATA_W-1:0]             wrData
);
  ctrlStrobe_t      strobe;
  logic [SLOTS-1:0] hitVec;
  logic             warpNew;

  ofs_control #(.NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .inUsed(srcUsed),
    .inReuse(reuseMask), .inIdx(srcIdx), .hitVec(hitVec), .warpNew(warpNew),
    .strobe(strobe), .inReady(inReady), .opValid(opValid)
  );

  ofs_datapath #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_WARPS(NUM_WARPS),
                 .NUM_BANKS(NUM_BANKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inWarp(warpId), .inIdx(srcIdx),
    .inUsed(srcUsed), .wrEn(wrEn), .wrWarp(wrWarp), .wrIdx(wrIdx), .wrData(wrData),
    .hitVec(hitVec), .warpNew(warpNew), .opData(opData)
  );
endmodule

// File: rtl/ofs_checker.sv
module ofs_checker #(
  parameter int NUM_REGS  = 16,
  parameter int NUM_BANKS = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          instValid,
  input logic                          inReady,
  input logic                          opValid,
  input logic [3:0]                    srcUsed,
  input logic [4*$clog2(NUM_REGS)-1:0] srcIdx
);
  localparam int REG_W  = $clog2(NUM_REGS);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic accepted;
  logic spread;
  assign accepted = instValid && inReady;

  always_comb begin
    spread = 1'b1;
    for (int a = 0; a < 4; a++)
      for (int b = a + 1; b < 4; b++)
        if (srcIdx[a*REG_W +: BANK_W] == srcIdx[b*REG_W +: BANK_W]) spread = 1'b0;
  end

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid);
  p_valid_when_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> inReady);
  p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> !inReady);
  p_no_sources_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && srcUsed == 4'b0000) |=> ##1 opValid);
  p_spread_banks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && srcUsed == 4'b1111 && spread) |=> ##1 opValid);
endmodule

bind operand_fetch ofs_checker #(.NUM_REGS(NUM_REGS), .NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rstN(rstN), .instValid(instValid), .inReady(inReady),
  .opValid(opValid), .srcUsed(srcUsed), .srcIdx(srcIdx)
);

// File: tb/sim_operand_fetch.sv
`timescale 1ns/1ps
module sim_operand_fetch;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instValid = 1'b0;
  logic          inReady;
  logic [1:0]    warpId = '0;
  logic [15:0]   srcIdx = '0;
  logic [3:0]    srcUsed = '0;
  logic [3:0]    reuseMask = '0;
  logic          opValid;
  logic [127:0]  opData;
  logic          wrEn = 1'b0;
  logic [1:0]    wrWarp = '0;
  logic [3:0]    wrIdx = '0;
  logic [31:0]   wrData = '0;

  int checks = 0;
  int failures = 0;
  int lat;
  logic readyAfterAccept;
  logic [31:0] got [4];
  logic [31:0] model [4][16];

  always #2.5 clk = ~clk;

  operand_fetch u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .inReady(inReady),
    .warpId(warpId), .srcIdx(srcIdx), .srcUsed(srcUsed), .reuseMask(reuseMask),
    .opValid(opValid), .opData(opData), .wrEn(wrEn), .wrWarp(wrWarp),
    .wrIdx(wrIdx), .wrData(wrData)
  );

  int cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int w, input int r, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrWarp = 2'(w); wrIdx = 4'(r); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    model[w][r] = d;
  endtask

  task automatic issue(input int w, input int i0, input int i1, input int i2, input int i3,
                       input logic [3:0] used, input logic [3:0] reuse);
    while (!inReady) @(negedge clk);
    instValid = 1'b1; warpId = 2'(w);
    srcIdx = {4'(i3), 4'(i2), 4'(i1), 4'(i0)};
    srcUsed = used; reuseMask = reuse;
    @(negedge clk);
    instValid = 1'b0;
    readyAfterAccept = inReady;
    lat = 1;
    while (!opValid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    for (int s = 0; s < 4; s++) got[s] = opData[s*DW +: DW];
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 inReady in reset", 32'(inReady), 32'd1);
    chk("R1 opValid in reset", 32'(opValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 inReady after reset", 32'(inReady), 32'd1);
    chk("R1 opValid after reset", 32'(opValid), 32'd0);
  endtask

  task automatic t_distinct;
    issue(0, 0, 1, 2, 3, 4'b1111, 4'b0000);
    chk("R2 latency banks 0..3", 32'(lat), 32'd2);
    for (int s = 0; s < 4; s++) chk("R2 data", got[s], model[0][s]);
    issue(0, 7, 2, 13, 0, 4'b1111, 4'b0000);
    chk("R2 latency permuted banks", 32'(lat), 32'd2);
    chk("R2 data slot0", got[0], model[0][7]);
    chk("R2 data slot2", got[2], model[0][13]);
  endtask

  task automatic t_conflict;
    issue(0, 0, 4, 8, 12, 4'b1111, 4'b0000);
    chk("R3 four in bank0 latency", 32'(lat), 32'd5);
    chk("R3 data slot3", got[3], model[0][12]);
    chk("R3 data slot0", got[0], model[0][0]);
    issue(0, 4, 8, 12, 5, 4'b1111, 4'b0000);
    chk("R3 three in bank0 latency", 32'(lat), 32'd4);
    chk("R3 data slot3", got[3], model[0][5]);
    issue(0, 1, 5, 2, 6, 4'b1111, 4'b0000);
    chk("R3 two pairs latency", 32'(lat), 32'd3);
    chk("R3 data slot1", got[1], model[0][5]);
  endtask

  task automatic t_pulse;
    issue(0, 4, 8, 2, 3, 4'b1111, 4'b0000);
    chk("R4 inReady low after accept", 32'(readyAfterAccept), 32'd0);
    chk("R4 inReady with opValid", 32'(inReady), 32'd1);
    @(negedge clk);
    chk("R4 opValid single cycle", 32'(opValid), 32'd0);
  endtask

  task automatic t_reuse;
    logic [31:0] oldR1;
    oldR1 = model[0][1];
    issue(0, 1, 5, 0, 0, 4'b0011, 4'b0011);
    chk("R5 fill instruction latency", 32'(lat), 32'd3);
    issue(0, 1, 5, 0, 0, 4'b0011, 4'b0000);
    chk("R6 hits skip bank latency", 32'(lat), 32'd2);
    chk("R6 hit data slot1", got[1], model[0][5]);
    wrReg(0, 1, 32'h1111_0001);
    issue(0, 1, 5, 0, 0, 4'b0011, 4'b0000);
    chk("R6 stale cached value", got[0], oldR1);
  endtask

  task automatic t_position;
    issue(0, 5, 1, 0, 0, 4'b0011, 4'b0000);
    chk("R7 swapped slots miss latency", 32'(lat), 32'd3);
    chk("R7 slot1 reads bank", got[1], 32'h1111_0001);
  endtask

  task automatic t_lrw;
    issue(0, 2, 0, 0, 0, 4'b0001, 4'b0001);
    issue(0, 3, 0, 0, 0, 4'b0001, 4'b0001);
    issue(0, 2, 6, 0, 0, 4'b0011, 4'b0000);
    chk("R8 second entry kept", 32'(lat), 32'd2);
    issue(0, 1, 9, 0, 0, 4'b0011, 4'b0000);
    chk("R8 oldest entry evicted", 32'(lat), 32'd3);
    chk("R8 evicted reads bank", got[0], 32'h1111_0001);
    issue(0, 3, 7, 0, 0, 4'b0011, 4'b0000);
    chk("R8 newest entry present", 32'(lat), 32'd2);
    chk("R8 newest data", got[0], model[0][3]);
  endtask

  task automatic t_unused;
    issue(0, 4, 8, 0, 0, 4'b0001, 4'b0010);
    chk("R10 single source latency", 32'(lat), 32'd2);
    chk("R10 used slot data", got[0], model[0][4]);
    chk("R10 unused slot1 zero", got[1], 32'd0);
    chk("R10 unused slot3 zero", got[3], 32'd0);
    issue(0, 4, 8, 0, 0, 4'b0011, 4'b0000);
    chk("R10 unused reuse bit no fill", 32'(lat), 32'd3);
    issue(0, 1, 2, 3, 4, 4'b0000, 4'b1111);
    chk("R10 no sources latency", 32'(lat), 32'd2);
    chk("R10 no sources zero", got[2], 32'd0);
  endtask

  task automatic t_flush;
    issue(1, 3, 7, 0, 0, 4'b0011, 4'b0000);
    chk("R9 other warp misses", 32'(lat), 32'd3);
    chk("R9 other warp data", got[0], model[1][3]);
    issue(0, 3, 7, 0, 0, 4'b0011, 4'b0000);
    chk("R9 cache flushed on return", 32'(lat), 32'd3);
    chk("R9 data on return", got[1], model[0][7]);
  endtask

  task automatic t_write;
    wrReg(1, 2, 32'h2222_0002);
    issue(1, 2, 0, 0, 0, 4'b0001, 4'b0000);
    chk("R11 written value read", got[0], 32'h2222_0002);
    issue(0, 2, 0, 0, 0, 4'b0001, 4'b0000);
    chk("R11 other warp untouched", got[0], model[0][2]);
  endtask

  initial begin
    t_reset;
    for (int w = 0; w < 4; w++)
      for (int r = 0; r < 16; r++)
        wrReg(w, r, 32'hA000_0000 | 32'(w << 8) | 32'(r));
    t_distinct;
    t_conflict;
    t_pulse;
    t_reuse;
    t_position;
    t_lrw;
    t_unused;
    t_flush;
    t_write;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule